// File: doc/BRIEF.md
# Up-Counting Interval Timer

This block produces periodic tick interrupts for a processor. A 32-bit counter steps upward and, once it passes all-ones, raises an overflow flag and either reloads from a stored start value or drops to zero and halts. Software reaches it through a word-addressed register port: an address, a write strobe, write data, and read data that follows the address in the same cycle. A single level-sensitive interrupt line reports pending, unmasked overflows.

Because the counter climbs toward all-ones, a period of N+1 counted steps is set by writing the complement of N (0xFFFFFFFF minus N) to both the start-value register and the counter. An optional prescaler slows the count by a power of two from 2 to 256. Status is cleared by writing a one to its bit. A read-only word reports the hardware version as two nibbles.

Word addresses (byte offset divided by four): version 0, status 6, interrupt mask 7, control 9, counter 10, start value 11. Control layout: bit 0 run, bit 1 reload-on-wrap, bits [4:2] prescale select, bit 5 prescale enable.

Top module: `tick_timer`

## Requirements
- R1: While run (control bit 0) is set and the prescaler is off, the counter (word 10) rises by exactly one on every clock.
- R2: With control bit 5 set, the counter steps once every 2^(sel+1) clocks, sel being control bits [4:2] (2 to 256); any control write with bit 0 set restarts the prescale count, so the next step comes a full ratio later.
- R3: When the counter steps from 0xFFFFFFFF with reload (control bit 1) set, it takes the start value (word 11), giving a period of N+1 steps for a start of 0xFFFFFFFF minus N.
- R4: When the counter steps from 0xFFFFFFFF with reload clear, it becomes zero and control bit 0 clears by itself, so counting stops.
- R5: The interrupt output is high exactly when status bit 1 and mask bit 1 (word 7, readable) are both set.
- R6: Every wrap sets status bit 1 (word 6); writing 1 to that bit clears it, writing 0 leaves it alone, and a wrap in the same cycle as a clearing write leaves it set.
- R7: Word 0 reads the major version in bits [7:4] and the minor version in bits [3:0] (defaults 2 and 1, read 0x21) and ignores writes.
- R8: A write to word 10 sets the counter without altering word 11, and a write to word 11 does not alter the counter.
- R9: Writing 0 to word 9 stops the counter, which then holds its value, and reads back control as zero.
- R10: All other word addresses, including 16, read as zero and writes to them change nothing.
- R11: After reset, control, status, mask, counter and start value are all zero and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Word address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq | output | 1 | Level interrupt: pending and unmasked overflow |

## Verification
The period is measured in clocks from the start write to the interrupt over a set of start values and control words: the prescaler off against each of several ratios (2, 4, 8, 256), near-wrap starts against starts several steps away, and reload against one-shot. A wrong ratio, a missed restart or an off-by-one at the wrap changes the measured count. Directed cases then separate the contended status write from a plain clear, the reload path from the wrap-to-zero path, and restart-on-rewrite from a free-running prescaler.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int ADDR_W   = 5;
    localparam int PS_SEL_W = 3;
    localparam int PS_CNT_W = 1 << PS_SEL_W;
    localparam int FLAG_BIT = 1;

    localparam logic [ADDR_W-1:0] A_VERSION = 5'd0;
    localparam logic [ADDR_W-1:0] A_STATUS  = 5'd6;
    localparam logic [ADDR_W-1:0] A_MASK    = 5'd7;
    localparam logic [ADDR_W-1:0] A_CTRL    = 5'd9;
    localparam logic [ADDR_W-1:0] A_COUNT   = 5'd10;
    localparam logic [ADDR_W-1:0] A_START   = 5'd11;

    localparam int CTRL_W = PS_SEL_W + 3;

    // packed order reproduces the control word layout, bit 0 upward
    typedef struct packed {
        logic                ps_en;
        logic [PS_SEL_W-1:0] ps_sel;
        logic                reload;
        logic                run;
    } ctrl_t;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_STATUS,
        TGT_MASK,
        TGT_CTRL,
        TGT_COUNT,
        TGT_START
    } wr_target_e;

    function automatic wr_target_e decode_target(input logic we, input logic [ADDR_W-1:0] a);
        if (!we) return TGT_NONE;
        case (a)
            A_STATUS: return TGT_STATUS;
            A_MASK:   return TGT_MASK;
            A_CTRL:   return TGT_CTRL;
            A_COUNT:  return TGT_COUNT;
            A_START:  return TGT_START;
            default:  return TGT_NONE;
        endcase
    endfunction

    // terminal value of the prescale counter: 2^(sel+1) - 1
    function automatic logic [PS_CNT_W-1:0] ps_limit(input logic [PS_SEL_W-1:0] sel);
        logic [PS_CNT_W:0] span;
        span = (PS_CNT_W+1)'(1) << (int'(sel) + 1);
        return PS_CNT_W'(span - 1'b1);
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import tick_timer_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run_i,
    input  logic                ps_en_i,
    input  logic [PS_SEL_W-1:0] ps_sel_i,
    input  logic                restart_i,
    output logic                tick_o
);
    logic [PS_CNT_W-1:0] div_q;
    logic                at_end;

    assign at_end = (div_q == ps_limit(ps_sel_i));

    always_comb begin
        if (!run_i || restart_i) tick_o = 1'b0;
        else if (!ps_en_i)       tick_o = 1'b1;
        else                     tick_o = at_end;
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i || restart_i || !ps_en_i) div_q <= '0;
        else if (at_end)                            div_q <= '0;
        else                                        div_q <= div_q + 1'b1;
    end

    // with prescaling on, two steps never come in adjacent cycles
    AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick_o && ps_en_i) |=> (!tick_o || !ps_en_i)); // R2

    // a restart leaves the divider at zero
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (div_q == '0)); // R2

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             set_i,
    input  logic [CNT_W-1:0] set_val_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] start_i,
    output logic [CNT_W-1:0] value_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] val_q;
    logic             at_top;

    assign at_top  = &val_q;
    assign wrap_o  = step_i && !set_i && at_top;
    assign value_o = val_q;

    always_ff @(posedge clk) begin
        if (rst)          val_q <= '0;
        else if (set_i)   val_q <= set_val_i;
        else if (step_i)  val_q <= at_top ? (reload_i ? start_i : '0) : val_q + 1'b1;
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (step_i && !set_i && !at_top) |=> (value_o == CNT_W'($past(value_o) + 1'b1))); // R1

    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        (wrap_o && reload_i) |=> (value_o == $past(start_i))); // R3

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wrap_o && !reload_i) |=> (value_o == '0)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !set_i) |=> $stable(value_o)); // R9

endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int VER_MAJOR = 2,
    parameter int VER_MINOR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              wrap_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  start_o,
    output logic              count_set_o,
    output logic              restart_o,
    output logic [CNT_W-1:0]  rdata_o,
    output logic              irq_o
);
    localparam logic [3:0] V_MAJ = 4'(VER_MAJOR);
    localparam logic [3:0] V_MIN = 4'(VER_MINOR);

    wr_target_e       tgt;
    ctrl_t            ctrl_q;
    logic             flag_q;
    logic             mask_q;
    logic [CNT_W-1:0] start_q;
    logic             clear_req;

    assign tgt         = decode_target(we_i, addr_i);
    assign clear_req   = (tgt == TGT_STATUS) && wdata_i[FLAG_BIT];
    assign count_set_o = (tgt == TGT_COUNT);
    assign restart_o   = (tgt == TGT_CTRL) && wdata_i[0];
    assign ctrl_o      = ctrl_q;
    assign start_o     = start_q;
    assign irq_o       = flag_q && mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (tgt == TGT_CTRL) begin
            ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        end else if (wrap_i && !ctrl_q.reload) begin
            ctrl_q.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= (flag_q && !clear_req) || wrap_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= 1'b0;
            start_q <= '0;
        end else begin
            if (tgt == TGT_MASK)  mask_q  <= wdata_i[FLAG_BIT];
            if (tgt == TGT_START) start_q <= wdata_i;
        end
    end

    always_comb begin
        case (addr_i)
            A_VERSION: rdata_o = CNT_W'({V_MAJ, V_MIN});
            A_STATUS:  rdata_o = CNT_W'(flag_q) << FLAG_BIT;
            A_MASK:    rdata_o = CNT_W'(mask_q) << FLAG_BIT;
            A_CTRL:    rdata_o = CNT_W'(ctrl_q);
            A_COUNT:   rdata_o = count_i;
            A_START:   rdata_o = start_q;
            default:   rdata_o = '0;
        endcase
    end

    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        wrap_i |=> flag_q); // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clear_req && !wrap_i) |=> !flag_q); // R6

    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clear_req) |=> flag_q); // R6

    AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (rst)
        (wrap_i && !ctrl_q.reload && tgt != TGT_CTRL) |=> !ctrl_q.run); // R4

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int VER_MAJOR = 2,
    parameter int VER_MINOR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] start_val;
    logic [CNT_W-1:0] count_val;
    logic             count_set;
    logic             restart;
    logic             step;
    logic             wrap;

    tick_regs #(
        .CNT_W     (CNT_W),
        .VER_MAJOR (VER_MAJOR),
        .VER_MINOR (VER_MINOR)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .addr_i      (bus_addr),
        .we_i        (bus_we),
        .wdata_i     (bus_wdata),
        .count_i     (count_val),
        .wrap_i      (wrap),
        .ctrl_o      (ctrl),
        .start_o     (start_val),
        .count_set_o (count_set),
        .restart_o   (restart),
        .rdata_o     (bus_rdata),
        .irq_o       (irq)
    );

    tick_prescaler u_presc (
        .clk       (clk),
        .rst       (rst),
        .run_i     (ctrl.run),
        .ps_en_i   (ctrl.ps_en),
        .ps_sel_i  (ctrl.ps_sel),
        .restart_i (restart),
        .tick_o    (step)
    );

    tick_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .step_i    (step),
        .set_i     (count_set),
        .set_val_i (bus_wdata),
        .reload_i  (ctrl.reload),
        .start_i   (start_val),
        .value_o   (count_val),
        .wrap_o    (wrap)
    );

    // a stopped timer never steps
    AST_STOPPED_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |-> !step); // R9

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        (irq && !(bus_we && bus_addr == A_MASK)) |=> (irq || !$past(wrap) || $past(bus_we))); // R5

endmodule

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [4:0] W_VER = 5'd0, W_STAT = 5'd6, W_MASK = 5'd7,
                           W_CTRL = 5'd9, W_CNT = 5'd10, W_START = 5'd11;

    localparam int NV = 6;
    localparam logic [31:0] V_CTRL  [NV] = '{32'h03, 32'h01, 32'h23, 32'h27, 32'h3F, 32'h2B};
    localparam logic [31:0] V_START [NV] = '{32'hFFFF_FFFD, 32'hFFFF_FFFF, 32'hFFFF_FFFE,
                                             32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFD};
    localparam int          V_EDGES [NV] = '{3, 1, 4, 4, 256, 24};

    tick_timer u_tick_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic edges_to_irq(output int k);
        k = 0;
        while (!irq && k < 1000) begin
            @(posedge clk); #1;
            k++;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v, held;
        int k;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R11 reset state
        rd(W_CTRL, v);  chk("R11 ctrl", v, 32'h0);
        rd(W_STAT, v);  chk("R11 status", v, 32'h0);
        rd(W_MASK, v);  chk("R11 mask", v, 32'h0);
        rd(W_CNT, v);   chk("R11 count", v, 32'h0);
        rd(W_START, v); chk("R11 start", v, 32'h0);
        chk("R11 irq", {31'b0, irq}, 32'h0);
        rd(W_VER, v);   chk("R7 version", v, 32'h21);

        // period table: R1 R2 R3 R4 clocks from start write to interrupt
        wr(W_MASK, 32'h2);
        for (int i = 0; i < NV; i++) begin
            wr(W_CTRL, 32'h0);
            wr(W_STAT, 32'h2);
            wr(W_CNT, V_START[i]);
            wr(W_CTRL, V_CTRL[i]);
            edges_to_irq(k);
            chk($sformatf("R2 R3 period vector %0d", i), 32'(k), 32'(V_EDGES[i]));
        end

        // R8 counter write leaves start value, R3 reload
        wr(W_CTRL, 32'h0);
        wr(W_START, 32'hFFFF_FFF0);
        wr(W_CNT, 32'hFFFF_FFFF);
        rd(W_START, v); chk("R8 start kept", v, 32'hFFFF_FFF0);
        rd(W_CNT, v);   chk("R8 count set", v, 32'hFFFF_FFFF);
        wr(W_CTRL, 32'h3);
        edges(1);
        rd(W_CNT, v);   chk("R3 reload", v, 32'hFFFF_FFF0);

        // R1 single steps
        wr(W_CTRL, 32'h0);
        wr(W_CNT, 32'd100);
        wr(W_CTRL, 32'h1);
        edges(5);
        rd(W_CNT, v);   chk("R1 step", v, 32'd105);

        // R9 stop holds
        wr(W_CTRL, 32'h0);
        rd(W_CNT, held);
        edges(5);
        rd(W_CNT, v);   chk("R9 hold", v, held);
        rd(W_CTRL, v);  chk("R9 ctrl zero", v, 32'h0);

        // R4 one-shot
        wr(W_STAT, 32'h2);
        wr(W_CNT, 32'hFFFF_FFFF);
        wr(W_CTRL, 32'h1);
        edges(1);
        rd(W_CNT, v);   chk("R4 wrap zero", v, 32'h0);
        rd(W_CTRL, v);  chk("R4 run cleared", v, 32'h0);
        edges(3);
        rd(W_CNT, v);   chk("R4 stays zero", v, 32'h0);

        // R6 write-one-to-clear
        rd(W_STAT, v);  chk("R6 flag set", v, 32'h2);
        wr(W_STAT, 32'h0);
        rd(W_STAT, v);  chk("R6 zero write", v, 32'h2);
        wr(W_STAT, 32'h2);
        rd(W_STAT, v);  chk("R6 clear", v, 32'h0);
        wr(W_CNT, 32'hFFFF_FFFF);
        wr(W_CTRL, 32'h1);
        wr(W_STAT, 32'h2);
        rd(W_STAT, v);  chk("R6 wrap beats clear", v, 32'h2);

        // R5 masking
        chk("R5 irq on", {31'b0, irq}, 32'h1);
        wr(W_MASK, 32'h0);
        chk("R5 irq masked", {31'b0, irq}, 32'h0);
        rd(W_MASK, v);  chk("R5 mask read", v, 32'h0);
        wr(W_MASK, 32'h2);
        chk("R5 irq back", {31'b0, irq}, 32'h1);

        // R2 restart on rewrite
        wr(W_CTRL, 32'h0);
        wr(W_STAT, 32'h2);
        wr(W_CNT, 32'hFFFF_FFFF);
        wr(W_CTRL, 32'h27);
        wr(W_CTRL, 32'h27);
        edges_to_irq(k);
        chk("R2 restart", 32'(k), 32'd4);

        // R7 version ignores writes
        wr(W_VER, 32'hFFFF_FFFF);
        rd(W_VER, v);   chk("R7 read-only", v, 32'h21);

        // R10 unmapped words
        wr(5'd16, 32'h5555_5555);
        rd(5'd16, v);   chk("R10 word 16", v, 32'h0);
        rd(5'd1, v);    chk("R10 word 1", v, 32'h0);
        rd(W_CTRL, v);  chk("R10 ctrl untouched", v, 32'h27);

        summary();
    end

endmodule